// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. Each line is fixed at build time either to capture rising edges or to follow a level. A captured event stays latched in a per-source status bit until software clears it by writing a one to that bit's position in the acknowledge register. A source counts as pending when its status bit and its enable bit are both set. The processor interrupt is raised when at least one source is pending and both bits of the master-enable register are set.

Software reaches the block through a word-addressed register port with eight offsets. Enable bits can be loaded all at once. They can also be set or cleared one at a time through two write-one-only offsets, so no read-modify-write is needed. A vector register gives the number of the lowest-numbered pending source, or all ones when nothing is pending. A usual start-up writes zero to enable, writes all ones to acknowledge, and then writes 3 to master-enable.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, status, enable and master-enable read as zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: A source whose bit in `EDGE_MASK` is 1 sets its status bit on the clock edge after its input goes from 0 to 1, whether or not it is enabled. The bit then stays set, even after the input falls, until it is acknowledged. Holding the input high does not set the bit again.
- R3: A source whose bit in `EDGE_MASK` is 0 sets its status bit on every clock edge at which its input is high. If it is acknowledged while the input is still high, it reads 0 for one cycle and is set again on the next edge.
- R4: A write to offset 3 (acknowledge) clears the status bits that are 1 in the written mask and leaves the other status bits as they were. The acknowledge wins over a capture on the same edge.
- R5: A write to offset 2 (enable) loads the enable register with the written value.
- R6: A write to offset 4 (set-enable) sets the enable bits that are 1 in the mask and leaves all other enable bits unchanged.
- R7: A write to offset 5 (clear-enable) clears the enable bits that are 1 in the mask and leaves all other enable bits unchanged.
- R8: Offset 1 (pending) reads as the bitwise AND of status (offset 0) and enable.
- R9: `irq_out` is high exactly when pending is nonzero and master-enable (offset 7, bits 1:0) equals 3.
- R10: Offset 6 (vector) reads the index of the lowest-numbered pending bit, so source 0 has the highest priority. It reads 0xFFFFFFFF when nothing is pending, whatever the master-enable setting.
- R11: Writes to offsets 0, 1 and 6 change no state. Offsets 3, 4 and 5 read as zero.
- R12: Master-enable stores only bits 1:0 of a write to offset 7. Its bits 31:2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | N_SRC | Interrupt request lines, synchronous to clk |
| reg_addr | input | 3 | Word offset of the register accessed |
| reg_we | input | 1 | Write strobe; write takes effect at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The bench acknowledges a level source while its input is still high. A design that gives capture priority over acknowledge would keep the bit set instead of reading zero for one cycle. It holds an edge source high across an acknowledge. A design that treats edge sources as levels would set that bit again. It fills status with several bits so that the vector must pick the lowest one, and it clears every pending bit so the vector must return all ones. A reversed priority or a stale idle value shows up as a wrong vector read. Random set/clear-enable masks catch designs that load the mask instead of merging it. Writes to read-only offsets and an all-ones master write catch decoding slips and upper master bits that were stored by mistake.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        OFF_STATUS = 3'd0,
        OFF_PEND   = 3'd1,
        OFF_ENABLE = 3'd2,
        OFF_ACK    = 3'd3,
        OFF_SETEN  = 3'd4,
        OFF_CLREN  = 3'd5,
        OFF_VECTOR = 3'd6,
        OFF_MASTER = 3'd7
    } reg_off_e;

    localparam logic [1:0] MASTER_ON = 2'b11;
endpackage

// File: rtl/irq_capture.sv
// Per-source capture event: rising edge or level, chosen by EDGE_MASK.
module irq_capture #(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
    input  logic [N_SRC-1:0] src,
    input  logic [N_SRC-1:0] src_prev,
    output logic [N_SRC-1:0] set_evt
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            always_comb set_evt[i] = src[i] & ~src_prev[i];
        end else begin : g_level
            logic unused_prev;
            always_comb unused_prev = src_prev[i];
            always_comb set_evt[i] = src[i];
        end
    end
endmodule

// File: rtl/irq_prio_find.sv
// Lowest-index set bit finder (index 0 wins).
module irq_prio_find #(
    parameter int N_SRC = 32,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_reg_read.sv
// Read multiplexer for the eight register offsets.
module irq_reg_read
    import irq_vec_pkg::*;
#(
    parameter int N_SRC = 32,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  status,
    input  logic [N_SRC-1:0]  pending,
    input  logic [N_SRC-1:0]  enable,
    input  logic              found,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        master,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (reg_off_e'(addr))
            OFF_STATUS: rdata = DATA_W'(status);
            OFF_PEND:   rdata = DATA_W'(pending);
            OFF_ENABLE: rdata = DATA_W'(enable);
            OFF_VECTOR: rdata = found ? DATA_W'(idx) : '1;
            OFF_MASTER: rdata = DATA_W'(master);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     src_in,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_out
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        logic [N_SRC-1:0] status;
        logic [N_SRC-1:0] enable;
        logic [N_SRC-1:0] prev;
        logic [1:0]       master;
    } state_t;

    state_t st_d, st_q;

    logic [N_SRC-1:0] set_evt;
    logic [N_SRC-1:0] pend_w;
    logic [N_SRC-1:0] wmask;
    logic             vec_found;
    logic [IDX_W-1:0] vec_idx;
    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] enable_q;
    logic [1:0]       master_q;
    logic             irq_q;
    logic             irq_d;
    logic [DATA_W-N_SRC:0] unused_wdata;

    assign wmask        = reg_wdata[N_SRC-1:0];
    assign unused_wdata = {1'b0, reg_wdata[DATA_W-1:N_SRC]} ;

    irq_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) cap_i (
        .src      (src_in),
        .src_prev (st_q.prev),
        .set_evt  (set_evt)
    );

    assign pend_w = st_q.status & st_q.enable;

    irq_prio_find #(.N_SRC(N_SRC)) prio_i (
        .req   (pend_w),
        .found (vec_found),
        .idx   (vec_idx)
    );

    irq_reg_read #(.N_SRC(N_SRC)) rd_i (
        .addr    (reg_addr),
        .status  (st_q.status),
        .pending (pend_w),
        .enable  (st_q.enable),
        .found   (vec_found),
        .idx     (vec_idx),
        .master  (st_q.master),
        .rdata   (reg_rdata)
    );

    always_comb begin
        logic [N_SRC-1:0] ack_mask;
        st_d      = st_q;
        st_d.prev = src_in;
        ack_mask  = (reg_we && reg_off_e'(reg_addr) == OFF_ACK) ? wmask : '0;
        // acknowledge has priority over a capture on the same edge
        st_d.status = (st_q.status | set_evt) & ~ack_mask;
        if (reg_we) begin
            unique case (reg_off_e'(reg_addr))
                OFF_ENABLE: st_d.enable = wmask;
                OFF_SETEN:  st_d.enable = st_q.enable | wmask;
                OFF_CLREN:  st_d.enable = st_q.enable & ~wmask;
                OFF_MASTER: st_d.master = reg_wdata[1:0];
                default:    ;
            endcase
        end
        irq_d = vec_found && (st_q.master == MASTER_ON);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_q    = irq_d;
    assign irq_out  = irq_q;
    assign status_q = st_q.status;
    assign enable_q = st_q.enable;
    assign master_q = st_q.master;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
    parameter int N_SRC = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             irq_out,
    input logic [N_SRC-1:0] status_q,
    input logic [N_SRC-1:0] enable_q,
    input logic [1:0]       master_q,
    input logic             vec_found
);
    AST_SETEN_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd4) |=> ((enable_q & $past(reg_wdata[N_SRC-1:0])) == $past(reg_wdata[N_SRC-1:0]))); // R6
    AST_CLREN_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd5) |=> ((enable_q & $past(reg_wdata[N_SRC-1:0])) == '0)); // R7
    AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd3) |=> ((status_q & $past(reg_wdata[N_SRC-1:0])) == '0)); // R4
    AST_IRQ_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (master_q == 2'b11)); // R9
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_found |-> !irq_out); // R9
    AST_MASTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == 3'd7) |=> $stable(master_q)); // R12
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N_SRC(N_SRC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .master_q  (master_q),
    .vec_found (vec_found)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
    localparam logic [31:0] EDGE = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_stat = '0, m_en = '0, m_prev = '0;
    logic [1:0]  m_mst = '0;

    always #10 clk = ~clk;

    irq_vec_ctrl #(.N_SRC(32), .EDGE_MASK(EDGE)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_vec(input logic [31:0] p);
        logic [31:0] v = 32'hFFFF_FFFF;
        for (int i = 31; i >= 0; i--) if (p[i]) v = i;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // one clock: drive after negedge, update model at posedge, return after negedge
    task automatic step(input logic [31:0] s, input bit we, input logic [2:0] a, input logic [31:0] d);
        logic [31:0] set_m, ack_m;
        src_in = s; reg_we = we; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        set_m = (s & EDGE & ~m_prev) | (s & ~EDGE);
        ack_m = (we && a == 3'd3) ? d : '0;
        m_stat = (m_stat | set_m) & ~ack_m;
        if (we) begin
            case (a)
                3'd2: m_en = d;
                3'd4: m_en = m_en | d;
                3'd5: m_en = m_en & ~d;
                3'd7: m_mst = d[1:0];
                default: ;
            endcase
        end
        m_prev = s;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic check_all();
        logic [31:0] p;
        p = m_stat & m_en;
        rd(3'd0, "R2/R3 status", m_stat);
        rd(3'd1, "R8 pending", p);
        rd(3'd2, "R5/R6/R7 enable", m_en);
        rd(3'd6, "R10 vector", exp_vec(p));
        rd(3'd7, "R12 master", {30'b0, m_mst});
        chk("R9 irq", {31'b0, irq_out}, {31'b0, (p != 0) && (m_mst == 2'b11)});
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, "R1 status", 32'h0);
        rd(3'd2, "R1 enable", 32'h0);
        rd(3'd7, "R1 master", 32'h0);
        rd(3'd6, "R1 vector", 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);

        // start-up sequence
        step('0, 1, 3'd2, 32'h0);
        step('0, 1, 3'd3, 32'hFFFF_FFFF);
        step('0, 1, 3'd7, 32'h3);
        check_all();

        // R3 level source 0: ack while high clears for one cycle then re-sets
        step(32'h1, 0, 3'd0, 0);
        rd(3'd0, "R3 level set", 32'h1);
        step(32'h1, 1, 3'd3, 32'h1);
        rd(3'd0, "R3 ack while high", 32'h0);
        step(32'h1, 0, 3'd0, 0);
        rd(3'd0, "R3 re-set", 32'h1);
        step(32'h0, 1, 3'd3, 32'h1);
        rd(3'd0, "R3 cleared", 32'h0);

        // R2 edge source 16, not enabled, held high across an ack
        step(32'h0001_0000, 0, 3'd0, 0);
        rd(3'd0, "R2 edge captured", 32'h0001_0000);
        step(32'h0001_0000, 1, 3'd3, 32'h0001_0000);
        step(32'h0001_0000, 0, 3'd0, 0);
        rd(3'd0, "R2 no re-capture while high", 32'h0);
        step(32'h0, 0, 3'd0, 0);
        step(32'h0001_0000, 0, 3'd0, 0);
        step(32'h0, 0, 3'd0, 0);
        rd(3'd0, "R2 latched after fall", 32'h0001_0000);

        // R10 priority: sources 5, 9 and 16 captured, all enabled
        step(32'h0000_0220, 1, 3'd2, 32'hFFFF_FFFF);
        rd(3'd6, "R10 lowest wins", 32'd5);
        chk("R9 irq on", {31'b0, irq_out}, 32'h1);
        step(32'h0, 1, 3'd3, 32'h0000_0020);
        rd(3'd6, "R10 next lowest", 32'd9);
        // R4 partial ack leaves others
        rd(3'd0, "R4 partial ack", 32'h0001_0200);
        step(32'h0, 1, 3'd5, 32'h0001_0200);
        rd(3'd6, "R10 idle vector", 32'hFFFF_FFFF);
        rd(3'd2, "R7 clear-enable", 32'hFFFE_FDFF);
        step(32'h0, 1, 3'd4, 32'h0000_0200);
        rd(3'd2, "R6 set-enable", 32'hFFFE_FFFF);

        // R11 read-only offsets and write-only reads
        step(32'h0, 1, 3'd0, 32'hFFFF_FFFF);
        step(32'h0, 1, 3'd1, 32'hFFFF_FFFF);
        step(32'h0, 1, 3'd6, 32'h0);
        rd(3'd0, "R11 status unchanged", 32'h0001_0200);
        rd(3'd2, "R11 enable unchanged", 32'hFFFE_FFFF);
        rd(3'd3, "R11 ack reads 0", 32'h0);
        rd(3'd4, "R11 seten reads 0", 32'h0);
        rd(3'd5, "R11 clren reads 0", 32'h0);

        // R12 master width, R9 master gating
        step(32'h0, 1, 3'd7, 32'hFFFF_FFFE);
        rd(3'd7, "R12 master bits", 32'h2);
        chk("R9 irq gated", {31'b0, irq_out}, 32'h0);
        rd(3'd6, "R10 vector ungated", 32'd9);
        step(32'h0, 1, 3'd7, 32'hFFFF_FFFF);
        check_all();

        // random phase
        s = '0;
        for (int n = 0; n < 2500; n++) begin
            logic [2:0] a;
            s = s ^ ($urandom & $urandom & $urandom);
            a = 3'($urandom_range(0, 7));
            step(s, ($urandom_range(0, 2) == 0), a,
                 (a == 3'd7) ? 32'($urandom_range(0, 3)) : ($urandom & $urandom));
            check_all();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule